// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block picks which of five maskable interrupt requests the processor takes next. The five sources are two external request lines, two timer overflow flags and one serial flag, which is the receive and transmit flags already merged into one. Software sets two 8-bit registers through a simple write port. One register holds a global enable and a mask bit for each source. The other holds a priority bit for each source, which places the source at the high level or the low level.

Arbitration has two stages. The programmed level is compared first. Inside one level a fixed order settles ties. The block keeps one in-service flag per level. A new request is accepted only if no handler at its own level or above is still running. A high-level request can therefore interrupt a low-level handler, but a request never interrupts a handler at the same level.

When the processor reports an instruction boundary and a request is accepted, the block sends back a one-cycle acknowledge. The acknowledge carries the winning source index, its level and its vector address. A return strobe closes the innermost open handler. Reset sends execution to address 0x0000 and never goes through this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `ack_o` is 0, `ack_vec_o` is 0x0000 and `in_service_o` is 0. Both registers are clear, so no request is acknowledged until software writes the enables.
- R2: Register select 0 writes the enable register. Bit 7 is the global enable. Bits 0 to 4 enable, in order, external 0, timer 0, external 1, timer 1 and serial. A request can be accepted only if the global bit and its own bit are both 1. Bits 5 and 6 have no effect.
- R3: Register select 1 writes the priority register. Bits 0 to 4 map to the sources in the same order as in R2. A 1 places the source at the high level (`ack_level_o` = 1) and a 0 places it at the low level.
- R4: Among enabled pending requests at the same level, the source with the lowest index wins. The indices are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3 and serial = 4.
- R5: An enabled pending high-level request wins over every low-level request, whatever their indices.
- R6: `ack_src_o` is the winner's index (0 to 4). `ack_vec_o` is 0x0003 + 8 × index, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R7: An acceptance happens only at a clock edge where `insn_bound_i` is 1. `ack_o` is high for the single cycle after that edge. Without a boundary, nothing is acknowledged.
- R8: An acceptance sets the in-service flag of the winner's level. `in_service_o[1]` is the high level and `in_service_o[0]` is the low level.
- R9: A low-level request is accepted only when neither flag is set. A high-level request is accepted only when the high flag is clear.
- R10: `reti_i` clears the highest in-service flag that is set. With no flag set, it has no effect.
- R11: An acceptance is judged against the in-service flags and registers as they stood before any return strobe or register write at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 5 | Request flags, one per source, indexed in polling order |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 = enable, 1 = priority |
| wr_data_i | input | 8 | Register write data |
| insn_bound_i | input | 1 | Processor is at an instruction boundary |
| reti_i | input | 1 | Return-from-handler strobe |
| ack_o | output | 1 | One-cycle acknowledge |
| ack_src_o | output | 3 | Index of the acknowledged source |
| ack_vec_o | output | 16 | Vector address of the acknowledged source |
| ack_level_o | output | 1 | Level of the acknowledged source |
| in_service_o | output | 2 | In-service flags, bit 1 high level, bit 0 low level |

## Verification
The two functions that can land on the same edge are closing a handler with `reti_i` and accepting a new request. The bench provokes this from a state where only the low-level flag is set. In one case it raises `reti_i` together with a high-level request and a boundary. That request must be acknowledged and the flags must end at 2'b10. In the other case it raises `reti_i` together with a low-level request. That request must be turned away for that cycle, because the old low flag still blocks it, and it must then be taken at the next boundary. A register write at the same edge as an acceptance is checked in the same way: the acceptance must follow the old register value.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned NUM_SRC  = 5;
    localparam int unsigned SRC_W    = $clog2(NUM_SRC);
    localparam int unsigned NUM_LVL  = 2;
    localparam int unsigned LVL_W    = $clog2(NUM_LVL);
    localparam int unsigned REG_W    = 8;
    localparam int unsigned GIE_BIT  = 7;
    localparam int unsigned VEC_W    = 16;

    typedef logic [NUM_SRC-1:0] src_mask_t;
    typedef logic [SRC_W-1:0]   src_idx_t;
    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [NUM_LVL-1:0] lvl_mask_t;

    typedef enum logic [LVL_W-1:0] {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef enum logic {
        REG_ENABLE = 1'b0,
        REG_PRIO   = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic      gie;
        src_mask_t src_en;
        src_mask_t prio;
    } cfg_t;

    typedef struct packed {
        logic     found;
        src_idx_t idx;
    } pick_t;

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
        lvl_e     lvl;
    } grant_t;

    // Lowest set index wins: this is the fixed polling order within a level.
    function automatic pick_t first_set(input src_mask_t m);
        pick_t p;
        p = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.found = 1'b1;
                p.idx   = src_idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic vec_t vector_of(input src_idx_t idx, input vec_t base, input vec_t stride);
        return base + vec_t'(idx) * stride;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                REG_ENABLE: begin
                    cfg.gie    <= wr_data[GIE_BIT];
                    cfg.src_en <= wr_data[NUM_SRC-1:0];
                end
                REG_PRIO: begin
                    cfg.prio   <= wr_data[NUM_SRC-1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  src_mask_t eligible,
    input  src_mask_t prio,
    output grant_t    grant
);

    pick_t pick [NUM_LVL];

    // Stage one: split requests by programmed level; stage two: fixed order inside each.
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_level
        src_mask_t at_level;
        assign at_level = eligible & ((l == int'(LVL_HIGH)) ? prio : ~prio);
        assign pick[l]  = first_set(at_level);
    end

    always_comb begin
        grant = '0;
        if (pick[LVL_HIGH].found) begin
            grant.valid = 1'b1;
            grant.idx   = pick[LVL_HIGH].idx;
            grant.lvl   = LVL_HIGH;
        end else if (pick[LVL_LOW].found) begin
            grant.valid = 1'b1;
            grant.idx   = pick[LVL_LOW].idx;
            grant.lvl   = LVL_LOW;
        end
    end

endmodule

// File: rtl/irq_level_tracker.sv
module irq_level_tracker
    import irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lvl_e      cand_lvl,
    input  logic      accept,
    input  logic      reti,
    output logic      can_take,
    output lvl_mask_t in_service
);

    lvl_mask_t clr_mask;
    lvl_mask_t set_mask;

    // A candidate is blocked by any open handler at its own level or above.
    assign can_take = ~|(in_service >> cand_lvl);

    always_comb begin
        clr_mask = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (in_service[l]) begin
                clr_mask    = '0;
                clr_mask[l] = 1'b1;
            end
        end
        if (!reti) clr_mask = '0;
    end

    assign set_mask = accept ? (lvl_mask_t'(1) << cand_lvl) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_service <= '0;
        end else begin
            in_service <= (in_service & ~clr_mask) | set_mask;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter logic [15:0] VEC_BASE   = 16'h0003,
    parameter logic [15:0] VEC_STRIDE = 16'h0008
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  req_i,
    input  logic        wr_en_i,
    input  logic        wr_sel_i,
    input  logic [7:0]  wr_data_i,
    input  logic        insn_bound_i,
    input  logic        reti_i,
    output logic        ack_o,
    output logic [2:0]  ack_src_o,
    output logic [15:0] ack_vec_o,
    output logic        ack_level_o,
    output logic [1:0]  in_service_o
);

    cfg_t      cfg;
    src_mask_t eligible;
    grant_t    grant;
    logic      can_take;
    logic      accept;
    lvl_mask_t in_service;

    irq_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .wr_sel  (reg_sel_e'(wr_sel_i)),
        .wr_data (wr_data_i),
        .cfg     (cfg)
    );

    assign eligible = req_i & cfg.src_en & {NUM_SRC{cfg.gie}};

    irq_arbiter u_arb (
        .eligible (eligible),
        .prio     (cfg.prio),
        .grant    (grant)
    );

    assign accept = grant.valid & can_take & insn_bound_i;

    irq_level_tracker u_lvl (
        .clk        (clk),
        .rst        (rst),
        .cand_lvl   (grant.lvl),
        .accept     (accept),
        .reti       (reti_i),
        .can_take   (can_take),
        .in_service (in_service)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o       <= 1'b0;
            ack_src_o   <= '0;
            ack_vec_o   <= '0;
            ack_level_o <= 1'b0;
        end else begin
            ack_o <= accept;
            if (accept) begin
                ack_src_o   <= 3'(grant.idx);
                ack_vec_o   <= vector_of(grant.idx, VEC_BASE, VEC_STRIDE);
                ack_level_o <= grant.lvl;
            end
        end
    end

    assign in_service_o = in_service;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  req_i,
    input logic        insn_bound_i,
    input logic        reti_i,
    input logic        ack_o,
    input logic [2:0]  ack_src_o,
    input logic [15:0] ack_vec_o,
    input logic        ack_level_o,
    input logic [1:0]  in_service_o
);

    assert_ack_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> $past(insn_bound_i));

    assert_ack_had_request_R4: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> ((($past(req_i) >> ack_src_o) & 5'd1) != 5'd0));

    assert_src_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (ack_src_o < 3'd5));

    assert_vector_map_R6: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> (ack_vec_o == 16'h0003 + 16'(ack_src_o) * 16'd8));

    assert_level_marked_R8: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> in_service_o[ack_level_o]);

    assert_no_take_over_high_R9: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> !$past(in_service_o[1]));

    assert_low_needs_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_o && !ack_level_o) |-> ($past(in_service_o) == 2'b00));

    assert_reti_clears_high_R10: assert property (@(posedge clk) disable iff (rst)
        (reti_i && in_service_o[1]) |=> !in_service_o[1]);

    assert_reti_clears_low_R10: assert property (@(posedge clk) disable iff (rst)
        (reti_i && in_service_o == 2'b01) |=> !in_service_o[0]);

endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .insn_bound_i (insn_bound_i),
    .reti_i       (reti_i),
    .ack_o        (ack_o),
    .ack_src_o    (ack_src_o),
    .ack_vec_o    (ack_vec_o),
    .ack_level_o  (ack_level_o),
    .in_service_o (in_service_o)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;

    localparam int CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  req_i;
    logic        wr_en_i;
    logic        wr_sel_i;
    logic [7:0]  wr_data_i;
    logic        insn_bound_i;
    logic        reti_i;
    logic        ack_o;
    logic [2:0]  ack_src_o;
    logic [15:0] ack_vec_o;
    logic        ack_level_o;
    logic [1:0]  in_service_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #CLK_HALF clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req_i),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .insn_bound_i (insn_bound_i),
        .reti_i       (reti_i),
        .ack_o        (ack_o),
        .ack_src_o    (ack_src_o),
        .ack_vec_o    (ack_vec_o),
        .ack_level_o  (ack_level_o),
        .in_service_o (in_service_o)
    );

    typedef struct packed {
        logic [7:0] en;
        logic [4:0] pr;
        logic [4:0] rq;
        logic       ack;
        logic [2:0] src;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{8'h9F, 5'h00, 5'h1F, 1'b1, 3'd0},  // R4 all pending, ext0 first
        '{8'h9F, 5'h00, 5'h1E, 1'b1, 3'd1},  // R4
        '{8'h9F, 5'h00, 5'h18, 1'b1, 3'd3},  // R4
        '{8'h9F, 5'h00, 5'h10, 1'b1, 3'd4},  // R4 serial alone
        '{8'h9F, 5'h10, 5'h1F, 1'b1, 3'd4},  // R5 R3 serial raised high
        '{8'h9F, 5'h0C, 5'h1F, 1'b1, 3'd2},  // R5 R4 two high, lower index
        '{8'h1F, 5'h00, 5'h1F, 1'b0, 3'd0},  // R2 global off
        '{8'h9E, 5'h00, 5'h01, 1'b0, 3'd0},  // R2 source off
        '{8'hE1, 5'h00, 5'h01, 1'b1, 3'd0},  // R2 bits 5/6 harmless
        '{8'hE0, 5'h00, 5'h1F, 1'b0, 3'd0},  // R2 bits 5/6 enable nothing
        '{8'h9F, 5'h1F, 5'h06, 1'b1, 3'd1}   // R3 R4 all high
    };

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic boundary_pulse();
        insn_bound_i = 1'b1;
        step();
        insn_bound_i = 1'b0;
    endtask

    task automatic close_all();
        req_i = '0; reti_i = 1'b1;
        step(); step();
        reti_i = 1'b0;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(2 * CLK_HALF * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_i = '0; wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
        insn_bound_i = 1'b0; reti_i = 1'b0;
        step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1", "ack", 32'(ack_o), 32'd0);
        check("R1", "vec", 32'(ack_vec_o), 32'h0000);
        check("R1", "in_service", 32'(in_service_o), 32'd0);
        req_i = 5'h1F;
        boundary_pulse();
        check("R1", "ack with cleared regs", 32'(ack_o), 32'd0);
        req_i = '0;

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            write_reg(1'b0, TBL[i].en);
            write_reg(1'b1, 8'(TBL[i].pr));
            req_i = TBL[i].rq;
            boundary_pulse();
            check("R2", $sformatf("vec%0d ack", i), 32'(ack_o), 32'(TBL[i].ack));
            if (TBL[i].ack) begin
                check("R4", $sformatf("vec%0d src", i), 32'(ack_src_o), 32'(TBL[i].src));
                check("R6", $sformatf("vec%0d vector", i), 32'(ack_vec_o), 32'h3 + 32'(TBL[i].src) * 8);
                check("R3", $sformatf("vec%0d level", i), 32'(ack_level_o), 32'(TBL[i].pr[TBL[i].src]));
            end
            close_all();
        end

        // R7: no boundary, no acknowledge
        write_reg(1'b0, 8'h9F);
        write_reg(1'b1, 8'h02);
        req_i = 5'h01;
        step(); step();
        check("R7", "ack without boundary", 32'(ack_o), 32'd0);
        check("R7", "in_service without boundary", 32'(in_service_o), 32'd0);

        // R8 R9 R10 nesting
        insn_bound_i = 1'b1;
        step();
        check("R8", "low ack", 32'(ack_o), 32'd1);
        check("R8", "low level", 32'(ack_level_o), 32'd0);
        check("R8", "in_service low", 32'(in_service_o), 32'b01);
        req_i = 5'h05;
        step();
        check("R7", "single-cycle pulse", 32'(ack_o), 32'd0);
        check("R9", "same level blocked", 32'(in_service_o), 32'b01);
        req_i = 5'h07;
        step();
        insn_bound_i = 1'b0;
        check("R9", "high pre-empts low", 32'(ack_o), 32'd1);
        check("R9", "pre-empting src", 32'(ack_src_o), 32'd1);
        check("R8", "both levels", 32'(in_service_o), 32'b11);
        req_i = '0;
        reti_i = 1'b1;
        step();
        check("R10", "high closed first", 32'(in_service_o), 32'b01);
        step();
        check("R10", "low closed", 32'(in_service_o), 32'b00);
        step();
        reti_i = 1'b0;
        check("R10", "idle return harmless", 32'(in_service_o), 32'b00);

        // R11 collision: return + high acceptance
        req_i = 5'h01;
        boundary_pulse();
        req_i = '0;
        check("R11", "setup low open", 32'(in_service_o), 32'b01);
        req_i = 5'h02; reti_i = 1'b1; insn_bound_i = 1'b1;
        step();
        reti_i = 1'b0; insn_bound_i = 1'b0; req_i = '0;
        check("R11", "high ack with return", 32'(ack_o), 32'd1);
        check("R11", "flags after swap", 32'(in_service_o), 32'b10);
        close_all();

        // R11 collision: return + low request is blocked by old state
        req_i = 5'h01;
        boundary_pulse();
        req_i = 5'h04; reti_i = 1'b1; insn_bound_i = 1'b1;
        step();
        reti_i = 1'b0;
        check("R11", "low blocked at return edge", 32'(ack_o), 32'd0);
        check("R11", "flags cleared", 32'(in_service_o), 32'b00);
        step();
        insn_bound_i = 1'b0;
        check("R11", "low taken next boundary", 32'(ack_o), 32'd1);
        check("R11", "low src", 32'(ack_src_o), 32'd2);
        close_all();

        // R11: write at the acceptance edge does not affect it; R2 afterwards
        req_i = 5'h01;
        wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 8'h00; insn_bound_i = 1'b1;
        step();
        wr_en_i = 1'b0; insn_bound_i = 1'b0;
        check("R11", "old enables used", 32'(ack_o), 32'd1);
        close_all();
        req_i = 5'h01;
        boundary_pulse();
        check("R2", "new enables applied", 32'(ack_o), 32'd0);

        finish_run();
    end

endmodule